// File: doc/BRIEF.md
# Byte-Serial Variable-Length Adder

This block adds two two's-complement integers of any length up to 2^LEN_W-1 bytes, taking one byte of each operand per clock. The caller pulses a start input together with the operand length and an optional carry-in. It then streams matching byte pairs from the low end upward, marking each pair with a valid strobe. The carry moves in the same direction as the bytes, so each pair is added as soon as it arrives and no operand is buffered.

Each sum byte comes out one cycle after its pair is accepted, lowest byte first. Together with the top byte, a one-cycle completion pulse reports three things for the whole result: the carry out, signed overflow, and the sign. The datapath and control are the same for every width; only the length input changes.

Top module: `byte_serial_adder`

## Requirements
- R1: While reset is held and after its release, busy_o, res_valid_o, done_o, carry_o, ovf_o and sign_o are all 0.
- R2: A start pulse taken while idle with a nonzero length sets busy_o from the next cycle. Exactly that many result bytes then follow, lowest first, each on res_valid_o in the cycle after its operand pair is accepted.
- R3: Result byte i equals byte i of (A + B + cin), where A and B are the operands at the requested length and cin is carry_in_i sampled with the start pulse.
- R4: A cycle with a_valid_i low while busy consumes no bytes and produces no result byte. The sum is unaffected by such gaps.
- R5: done_o pulses for one cycle together with the final result byte, and busy_o is low in that cycle. carry_o is bit 8*len of A + B + cin.
- R6: sign_o is bit 7 of the final (most significant) result byte.
- R7: ovf_o is 1 exactly when bit 7 of both top operand bytes is equal and differs from bit 7 of the top result byte.
- R8: A start with length 0 gives done_o in the next cycle with carry_o, ovf_o and sign_o at 0, no result byte, and busy_o staying low.
- R9: A start pulse while busy is ignored: the running operation's count, carry and results are unchanged.
- R10: a_valid_i while idle is ignored: no result byte and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| len_i | input | LEN_W | Operand length in bytes, sampled with start_i |
| carry_in_i | input | 1 | Initial carry, sampled with start_i |
| a_valid_i | input | 1 | Operand byte pair present |
| a_byte_i | input | BYTE_W | Byte of first operand |
| b_byte_i | input | BYTE_W | Byte of second operand |
| busy_o | output | 1 | Operation in progress |
| res_valid_o | output | 1 | Result byte present |
| res_byte_o | output | BYTE_W | Result byte |
| done_o | output | 1 | Completion pulse |
| carry_o | output | 1 | Final carry out, valid with done_o |
| ovf_o | output | 1 | Signed overflow, valid with done_o |
| sign_o | output | 1 | Sign of result, valid with done_o |

## Verification
The assertions check several rules on every cycle. A result byte only follows an accepted pair, and idle cycles never emit one. Completion coincides with the end of busy, and the sign matches the top result byte. A zero length completes at once with clear flags, and a start during a gap cannot end the operation. The arithmetic itself is shown only by the bench's scenarios: byte values, carry propagation across byte boundaries, overflow, carry-in, and gaps in the valid strobe. The bench compares each of these against a full-width sum at several lengths.

// File: rtl/byte_serial_adder.sv
module byte_serial_adder #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              carry_in_i,
  input  logic              a_valid_i,
  input  logic [BYTE_W-1:0] a_byte_i,
  input  logic [BYTE_W-1:0] b_byte_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [BYTE_W-1:0] res_byte_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              sign_o
);
  localparam int TOP = BYTE_W - 1;

  logic             busy_q;
  logic [LEN_W-1:0] left_q;
  logic             cy_q;

  wire kick  = !busy_q && start_i;
  wire empty = kick && (len_i == '0);
  wire take  = busy_q && a_valid_i;
  wire last  = take && (left_q == LEN_W'(1));

  wire [BYTE_W:0] sum = {1'b0, a_byte_i} + {1'b0, b_byte_i} + {{BYTE_W{1'b0}}, cy_q};
  wire            ovf = (a_byte_i[TOP] == b_byte_i[TOP]) && (sum[TOP] != a_byte_i[TOP]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      left_q      <= '0;
      cy_q        <= 1'b0;
      res_valid_o <= 1'b0;
      res_byte_o  <= '0;
      done_o      <= 1'b0;
      carry_o     <= 1'b0;
      ovf_o       <= 1'b0;
      sign_o      <= 1'b0;
    end else begin
      res_valid_o <= take;
      done_o      <= last || empty;
      if (take) begin
        res_byte_o <= sum[BYTE_W-1:0];
        cy_q       <= sum[BYTE_W];
        left_q     <= left_q - LEN_W'(1);
      end
      if (kick) begin
        busy_q <= !empty;
        left_q <= len_i;
        cy_q   <= carry_in_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end
      if (last) begin
        carry_o <= sum[BYTE_W];
        sign_o  <= sum[TOP];
        ovf_o   <= ovf;
      end else if (empty) begin
        carry_o <= 1'b0;
        sign_o  <= 1'b0;
        ovf_o   <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

module byte_serial_adder_chk #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              a_valid_i,
  input logic              busy_o,
  input logic              res_valid_o,
  input logic [BYTE_W-1:0] res_byte_o,
  input logic              done_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic              sign_o
);
  assert_result_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(busy_o && a_valid_i));

  assert_gap_keeps_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !a_valid_i) |=> busy_o);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_sign_top_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_valid_o) |-> (sign_o == res_byte_o[BYTE_W-1]));

  assert_zero_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && len_i == '0) |=> (done_o && !carry_o && !ovf_o && !sign_o && !res_valid_o && !busy_o));

  assert_start_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !a_valid_i) |=> (busy_o && !done_o));

  assert_idle_no_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !res_valid_o);
endmodule

bind byte_serial_adder byte_serial_adder_chk #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/byte_serial_adder_test.sv
module byte_serial_adder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic       carry_in_i = 1'b0;
  logic       a_valid_i = 1'b0;
  logic [7:0] a_byte_i = '0;
  logic [7:0] b_byte_i = '0;
  logic       busy_o, res_valid_o, done_o, carry_o, ovf_o, sign_o;
  logic [7:0] res_byte_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  byte_serial_adder uut (.*);

  localparam int NV = 8;
  localparam logic [31:0] VA [0:NV-1] = '{32'h0000_0001, 32'h0000_00FF, 32'h0000_7FFF, 32'hFFFF_FFFF,
                                          32'h1234_5678, 32'h8000_0000, 32'h0000_00C0, 32'h00FF_FFFF};
  localparam logic [31:0] VB [0:NV-1] = '{32'h0000_0002, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001,
                                          32'h0FED_CBA9, 32'h8000_0000, 32'h0000_00C0, 32'h0000_0000};
  localparam int          VL [0:NV-1] = '{1, 2, 2, 4, 4, 4, 1, 3};
  localparam bit          VC [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  // gap_at: byte index before which one idle cycle is inserted (-1 for none)
  // poke_start: also raise start_i during that gap and on each byte cycle (R9)
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int len, input bit cin,
                        input int gap_at, input bit poke_start);
    logic [39:0] am, bm, full;
    bit sa, sb, sr;
    am   = {8'h00, a} & ((40'd1 << (8 * len)) - 40'd1);
    bm   = {8'h00, b} & ((40'd1 << (8 * len)) - 40'd1);
    full = am + bm + {39'd0, cin};
    sa = am[8*len-1]; sb = bm[8*len-1]; sr = full[8*len-1];
    start_i = 1'b1; len_i = 8'(len); carry_in_i = cin;
    cyc();
    start_i = 1'b0; carry_in_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        a_valid_i = 1'b0; a_byte_i = 8'hAA; b_byte_i = 8'h55;
        start_i = poke_start; len_i = 8'd0;
        cyc();
        start_i = 1'b0;
        check(res_valid_o == 1'b0 && done_o == 1'b0 && busy_o == 1'b1, "R4", "gap produced output",
              {res_valid_o, done_o, busy_o}, 3'b001);
        if (poke_start) check(done_o == 1'b0, "R9", "start while busy", done_o, 0);
      end
      a_valid_i = 1'b1; a_byte_i = a[8*i +: 8]; b_byte_i = b[8*i +: 8];
      start_i = poke_start; len_i = 8'd1;
      cyc();
      start_i = 1'b0; a_valid_i = 1'b0;
      check(res_valid_o == 1'b1, "R2", "result valid", res_valid_o, 1);
      check(res_byte_o == full[8*i +: 8], "R3", $sformatf("byte %0d", i), res_byte_o, full[8*i +: 8]);
      if (i == len - 1) begin
        check(done_o == 1'b1 && busy_o == 1'b0, "R5", "done at last byte", {done_o, busy_o}, 2'b10);
        check(carry_o == full[8*len], "R5", "carry out", carry_o, full[8*len]);
        check(sign_o == sr, "R6", "sign", sign_o, sr);
        check(ovf_o == ((sa == sb) && (sr != sa)), "R7", "overflow", ovf_o, (sa == sb) && (sr != sa));
      end else begin
        check(done_o == 1'b0, "R5", "early done", done_o, 0);
      end
    end
    cyc();
    check(res_valid_o == 1'b0 && done_o == 1'b0, "R5", "quiet after done", {res_valid_o, done_o}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        check(busy_o == 0 && res_valid_o == 0 && done_o == 0 && carry_o == 0 && ovf_o == 0 && sign_o == 0,
              "R1", "outputs in reset", {busy_o, res_valid_o, done_o, carry_o, ovf_o, sign_o}, 0);
        rst_n = 1'b1;
        cyc();
        check(busy_o == 0 && res_valid_o == 0 && done_o == 0, "R1", "idle after reset",
              {busy_o, res_valid_o, done_o}, 0);

        for (int v = 0; v < NV; v++) run_op(VA[v], VB[v], VL[v], VC[v], -1, 1'b0);

        run_op(32'h00FF_FFFF, 32'h0000_0001, 3, 1'b0, 1, 1'b0);
        run_op(32'h7F00_0000, 32'h0100_0000, 4, 1'b1, 2, 1'b1);

        // R8: zero length with carry-in set
        start_i = 1'b1; len_i = 8'd0; carry_in_i = 1'b1;
        cyc();
        start_i = 1'b0; carry_in_i = 1'b0;
        check(done_o == 1 && carry_o == 0 && ovf_o == 0 && sign_o == 0 && res_valid_o == 0 && busy_o == 0,
              "R8", "zero length", {done_o, carry_o, ovf_o, sign_o, res_valid_o, busy_o}, 6'b100000);
        cyc();
        check(done_o == 0, "R8", "single pulse", done_o, 0);

        // R10: valid while idle
        a_valid_i = 1'b1; a_byte_i = 8'h01; b_byte_i = 8'h01;
        cyc();
        a_valid_i = 1'b0;
        check(res_valid_o == 0 && done_o == 0, "R10", "idle valid ignored", {res_valid_o, done_o}, 0);
        cyc();
        check(busy_o == 0, "R10", "still idle", busy_o, 0);

        run_op(32'h0000_0080, 32'h0000_0080, 1, 1'b0, -1, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule